// File: doc/BRIEF.md
# Accelerator Command Stream Decoder

This block sits at the front of a neural-network accelerator and turns a stream of 32-bit program words into register writes and operation launches. Each header word carries a 16-bit command code in its low half and a 16-bit parameter in its high half. The two top bits of the code pick a payload mode. In one mode the header stands alone. In another, exactly one extra 32-bit word follows the header. The two remaining modes are illegal.

Set commands update a shadow register file through a registered write port. Operation commands raise a start request that carries the operation kind and the parameter. The request is held until the execution side acknowledges it. Two outstanding-operation counters, one for kernel work and one for DMA, rise on each acknowledged start and fall on completion pulses. Wait commands hold the stream until the chosen counter drops to the limit given in the command. A stop command ends the program, and the block stays finished until reset.

Top module: `cmdstream_decoder`

## Requirements
- R1: A no-payload header (code bits 15:14 = 00) whose opcode (code bits 9:0) is 0x100 or above writes {16'h0, parameter} to address = opcode, with reg_wr_wide low, visible the cycle after the header is accepted.
- R2: A header with code bits 15:14 = 01 makes no write on its own. The next accepted word is written to address = the header opcode, with reg_wr_wide high and reg_wr_aux = the header parameter.
- R3: No-payload opcodes 0x002, 0x003, 0x005, 0x006 and 0x010 raise op_start with op_kind 0, 1, 2, 3 and 4 respectively. op_param equals the header parameter. The request stays high and stable until a cycle with op_ack.
- R4: The parameter of a DMA start (opcode 0x010) is passed through unchanged, with the channel number times 16 plus a 4-bit mode.
- R5: An acknowledged start adds one to the kernel counter (kinds 0 to 3) or the DMA counter (kind 4). A kernel_done or dma_done pulse takes one away from its counter.
- R6: A DMA wait (opcode 0x011) holds the stream, with stalled high, while the DMA counter exceeds min(parameter, 15).
- R7: A kernel wait (opcode 0x012) holds the stream, with stalled high, while the kernel counter exceeds min(parameter, 3).
- R8: in_ready is low while a wait is stalled and while a start request is waiting for op_ack.
- R9: A stop (opcode 0x000, no payload) raises done and drops in_ready, and both stay so until reset.
- R10: A header with code bits 15:14 = 10 or 11 raises error and drops in_ready, and both stay so until reset.
- R11: After reset, in_ready is high and reg_wr_en, op_start, stalled, done and error are low.
- R12: No-payload opcodes below 0x100 that are not listed in R3, R6, R7 or R9 are dropped. They cause no write and no start, and the stream continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word valid |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Decoder accepts a word |
| reg_wr_en | output | 1 | Shadow register write strobe |
| reg_wr_wide | output | 1 | Write comes from a payload word |
| reg_wr_addr | output | 10 | Register address (opcode) |
| reg_wr_data | output | 32 | Register value |
| reg_wr_aux | output | 16 | Secondary field from the payload header |
| op_start | output | 1 | Operation start request |
| op_kind | output | 3 | 0 conv, 1 depthwise, 2 pool, 3 elementwise, 4 DMA |
| op_param | output | 16 | Operation parameter |
| op_ack | input | 1 | Execution side takes the start request |
| kernel_done | input | 1 | One kernel operation completed |
| dma_done | input | 1 | One DMA operation completed |
| stalled | output | 1 | A wait is holding the stream |
| done | output | 1 | Stop command reached |
| error | output | 1 | Illegal payload mode seen |

## Verification
The counter assertions assume the execution side never sends a completion pulse for a counter that is already zero. They also assume it never lets more operations pile up than the counter width can hold. The bench keeps its own count of outstanding operations per kind and sends completion pulses only against that count. It keeps at most five operations in flight. The wait sweeps then cover every mix of in-flight count and wait parameter, including parameters above the clamp limit.

// File: rtl/cmdstream_pkg.sv
package cmdstream_pkg;
   localparam int WORD_W = 32;
   localparam int PRM_W  = 16;
   localparam int OPC_W  = 10;

   localparam logic [OPC_W-1:0] OPC_STOP  = 10'h000;
   localparam logic [OPC_W-1:0] OPC_CONV  = 10'h002;
   localparam logic [OPC_W-1:0] OPC_DWISE = 10'h003;
   localparam logic [OPC_W-1:0] OPC_POOL  = 10'h005;
   localparam logic [OPC_W-1:0] OPC_ELTW  = 10'h006;
   localparam logic [OPC_W-1:0] OPC_DMA   = 10'h010;
   localparam logic [OPC_W-1:0] OPC_DWAIT = 10'h011;
   localparam logic [OPC_W-1:0] OPC_KWAIT = 10'h012;

   typedef enum logic [2:0] {
      OPK_CONV = 3'd0, OPK_DWISE = 3'd1, OPK_POOL = 3'd2,
      OPK_ELTW = 3'd3, OPK_DMA = 3'd4
   } op_kind_e;

   typedef enum logic [2:0] {
      CL_SETN, CL_HDRW, CL_OP, CL_WAITK, CL_WAITD, CL_STOP, CL_BAD, CL_NOP
   } cls_e;

   typedef enum logic [2:0] {
      ST_HDR, ST_PAY, ST_OP, ST_WAIT, ST_DONE, ST_ERR
   } dec_state_e;

   typedef struct packed {
      cls_e              cls;
      op_kind_e          kind;
      logic [OPC_W-1:0]  opc;
      logic [PRM_W-1:0]  prm;
   } hdr_info_t;
endpackage

// File: rtl/cs_header_decode.sv
module cs_header_decode
   import cmdstream_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output hdr_info_t         info
);
   logic [1:0]       mode;
   logic [OPC_W-1:0] opc;
   logic [3:0]       unused_code_bits;

   assign mode             = word[15:14];
   assign opc              = word[OPC_W-1:0];
   assign unused_code_bits = word[13:10];

   always_comb begin
      info.opc  = opc;
      info.prm  = word[WORD_W-1:16];
      info.kind = OPK_CONV;
      info.cls  = CL_NOP;
      if (mode[1]) begin
         info.cls = CL_BAD;
      end else if (mode[0]) begin
         info.cls = CL_HDRW;
      end else if (opc[OPC_W-1:8] != '0) begin
         info.cls = CL_SETN;
      end else begin
         unique case (opc)
            OPC_STOP:  info.cls = CL_STOP;
            OPC_CONV:  begin info.cls = CL_OP; info.kind = OPK_CONV;  end
            OPC_DWISE: begin info.cls = CL_OP; info.kind = OPK_DWISE; end
            OPC_POOL:  begin info.cls = CL_OP; info.kind = OPK_POOL;  end
            OPC_ELTW:  begin info.cls = CL_OP; info.kind = OPK_ELTW;  end
            OPC_DMA:   begin info.cls = CL_OP; info.kind = OPK_DMA;   end
            OPC_DWAIT: info.cls = CL_WAITD;
            OPC_KWAIT: info.cls = CL_WAITK;
            default:   info.cls = CL_NOP;
         endcase
      end
   end
endmodule

// File: rtl/cs_outstanding.sv
module cs_outstanding #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           count <= '0;
      else if (inc && !dec) count <= count + 1'b1;
      else if (dec && !inc) count <= count - 1'b1;
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec) |-> (count != CNT_MAX));

   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |-> (count != '0));
endmodule

// File: rtl/cmdstream_decoder.sv
module cmdstream_decoder
   import cmdstream_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter int KWAIT_MAX = 3,
   parameter int DWAIT_MAX = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       in_word,
   output logic              in_ready,
   output logic              reg_wr_en,
   output logic              reg_wr_wide,
   output logic [9:0]        reg_wr_addr,
   output logic [31:0]       reg_wr_data,
   output logic [15:0]       reg_wr_aux,
   output logic              op_start,
   output logic [2:0]        op_kind,
   output logic [15:0]       op_param,
   input  logic              op_ack,
   input  logic              kernel_done,
   input  logic              dma_done,
   output logic              stalled,
   output logic              done,
   output logic              error
);
   localparam int NCTR    = 2;
   localparam int IDX_KRN = 0;
   localparam int IDX_DMA = 1;

   initial begin
      cnt_width_chk: assert (CNT_W <= PRM_W && ((1 << CNT_W) - 1) >= DWAIT_MAX
                             && DWAIT_MAX >= KWAIT_MAX)
         else $error("CNT_W too small for wait limits");
   end

   dec_state_e        state;
   hdr_info_t         info;
   logic              acc;
   logic [OPC_W-1:0]  pend_opc;
   logic [PRM_W-1:0]  pend_prm;
   op_kind_e          kind_q;
   logic [PRM_W-1:0]  param_q;
   logic              wait_dma;
   logic [CNT_W-1:0]  wait_lim;
   logic [CNT_W-1:0]  lim_k, lim_d, sel_cnt;
   logic              wait_ok;
   logic [NCTR-1:0]   ctr_inc, ctr_dec;
   logic [CNT_W-1:0]  ctr_cnt [NCTR];

   cs_header_decode u_hdr (.word(in_word), .info(info));

   assign acc   = in_valid && in_ready;
   assign lim_k = (info.prm > PRM_W'(KWAIT_MAX)) ? CNT_W'(KWAIT_MAX) : CNT_W'(info.prm);
   assign lim_d = (info.prm > PRM_W'(DWAIT_MAX)) ? CNT_W'(DWAIT_MAX) : CNT_W'(info.prm);

   assign ctr_inc[IDX_KRN] = op_start && op_ack && (kind_q != OPK_DMA);
   assign ctr_inc[IDX_DMA] = op_start && op_ack && (kind_q == OPK_DMA);
   assign ctr_dec[IDX_KRN] = kernel_done;
   assign ctr_dec[IDX_DMA] = dma_done;

   for (genvar gi = 0; gi < NCTR; gi++) begin : g_ctr
      cs_outstanding #(.W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ctr_inc[gi]),
         .dec   (ctr_dec[gi]),
         .count (ctr_cnt[gi])
      );
   end

   assign sel_cnt = wait_dma ? ctr_cnt[IDX_DMA] : ctr_cnt[IDX_KRN];
   assign wait_ok = (sel_cnt <= wait_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_HDR;
         reg_wr_en   <= 1'b0;
         reg_wr_wide <= 1'b0;
         reg_wr_addr <= '0;
         reg_wr_data <= '0;
         reg_wr_aux  <= '0;
         pend_opc    <= '0;
         pend_prm    <= '0;
         kind_q      <= OPK_CONV;
         param_q     <= '0;
         wait_dma    <= 1'b0;
         wait_lim    <= '0;
      end else begin
         reg_wr_en <= 1'b0;
         unique case (state)
            ST_HDR: if (acc) begin
               unique case (info.cls)
                  CL_SETN: begin
                     reg_wr_en   <= 1'b1;
                     reg_wr_wide <= 1'b0;
                     reg_wr_addr <= info.opc;
                     reg_wr_data <= {16'h0, info.prm};
                     reg_wr_aux  <= '0;
                  end
                  CL_HDRW: begin
                     pend_opc <= info.opc;
                     pend_prm <= info.prm;
                     state    <= ST_PAY;
                  end
                  CL_OP: begin
                     kind_q  <= info.kind;
                     param_q <= info.prm;
                     state   <= ST_OP;
                  end
                  CL_WAITK: begin
                     wait_dma <= 1'b0;
                     wait_lim <= lim_k;
                     state    <= ST_WAIT;
                  end
                  CL_WAITD: begin
                     wait_dma <= 1'b1;
                     wait_lim <= lim_d;
                     state    <= ST_WAIT;
                  end
                  CL_STOP: state <= ST_DONE;
                  CL_BAD:  state <= ST_ERR;
                  default: ;
               endcase
            end
            ST_PAY: if (acc) begin
               reg_wr_en   <= 1'b1;
               reg_wr_wide <= 1'b1;
               reg_wr_addr <= pend_opc;
               reg_wr_data <= in_word;
               reg_wr_aux  <= pend_prm;
               state       <= ST_HDR;
            end
            ST_OP:   if (op_ack) state <= ST_HDR;
            ST_WAIT: if (wait_ok) state <= ST_HDR;
            default: ;
         endcase
      end
   end

   assign in_ready = (state == ST_HDR) || (state == ST_PAY);
   assign op_start = (state == ST_OP);
   assign op_kind  = kind_q;
   assign op_param = param_q;
   assign stalled  = (state == ST_WAIT) && !wait_ok;
   assign done     = (state == ST_DONE);
   assign error    = (state == ST_ERR);

   // R3
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !op_ack) |=> (op_start && $stable(op_param) && $stable(op_kind)));

   // R8
   stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled || op_start) |-> !in_ready);

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !in_ready && !op_start));

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> (error && !in_ready && !reg_wr_en));

   // R2
   pay_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_wide) |-> $past(in_valid));
endmodule

// File: tb/cmdstream_decoder_tb.sv
`timescale 1ns/1ps
module cmdstream_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_ready;
   logic        reg_wr_en, reg_wr_wide;
   logic [9:0]  reg_wr_addr;
   logic [31:0] reg_wr_data;
   logic [15:0] reg_wr_aux;
   logic        op_start;
   logic [2:0]  op_kind;
   logic [15:0] op_param;
   logic        op_ack = 1'b0, kernel_done = 1'b0, dma_done = 1'b0;
   logic        stalled, done, error;
   int          total = 0, bad = 0;

   always #4 clk = ~clk;

   cmdstream_decoder u_dut (.*);

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input logic [31:0] w);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pulse_done(input bit is_dma);
      if (is_dma) dma_done = 1'b1; else kernel_done = 1'b1;
      @(posedge clk);
      @(negedge clk);
      dma_done = 1'b0;
      kernel_done = 1'b0;
   endtask

   function automatic int kind_of(input logic [9:0] opc);
      case (opc)
         10'h002: return 0;
         10'h003: return 1;
         10'h005: return 2;
         10'h006: return 3;
         default: return 4;
      endcase
   endfunction

   task automatic issue_op(input logic [9:0] opc, input logic [15:0] prm, input int hold);
      send({prm, 6'b0, opc});
      chk(op_start === 1'b1, "R3 start", op_start, 1);
      chk(op_kind == 3'(kind_of(opc)), "R3 kind", op_kind, kind_of(opc));
      chk(op_param == prm, "R3/R4 param", op_param, prm);
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         chk(op_start && op_param == prm, "R3 hold", op_start, 1);
         chk(!in_ready, "R8 ready while pending", in_ready, 0);
      end
      op_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      op_ack = 1'b0;
      chk(!op_start, "R3 released", op_start, 0);
   endtask

   task automatic wait_sweep(input bit is_dma, input int maxlim, input int plist[9]);
      for (int n = 0; n <= 5; n++) begin
         for (int k = 0; k < 9; k++) begin
            int p = plist[k];
            int lim = (p > maxlim) ? maxlim : p;
            int cur = n;
            for (int i = 0; i < n; i++)
               issue_op(is_dma ? 10'h010 : 10'h005, 16'(i), 0);
            send({16'(p), 16'(is_dma ? 16'h0011 : 16'h0012)});
            chk(stalled == (cur > lim), is_dma ? "R6 R5 stall" : "R7 R5 stall", stalled, cur > lim);
            chk(!in_ready, "R8 ready in wait", in_ready, 0);
            while (cur > lim) begin
               pulse_done(is_dma);
               cur--;
               chk(stalled == (cur > lim), is_dma ? "R6 R5 release" : "R7 R5 release", stalled, cur > lim);
            end
            @(negedge clk);
            chk(in_ready && !stalled, is_dma ? "R6 resume" : "R7 resume", in_ready, 1);
            while (cur > 0) begin
               pulse_done(is_dma);
               cur--;
            end
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int dl[9] = '{0, 1, 2, 3, 4, 5, 15, 16, 200};
      int kl[9] = '{0, 1, 2, 3, 4, 5, 9, 300, 65535};
      do_reset();
      // R11
      chk(in_ready && !reg_wr_en && !op_start && !stalled && !done && !error,
          "R11 reset state", {in_ready, reg_wr_en, op_start, stalled, done, error}, 6'b100000);

      // R1 narrow writes
      for (int i = 0; i < 16; i++) begin
         logic [9:0]  a = 10'h100 + 10'(i * 45);
         logic [15:0] p = 16'(i * 4099 + 7);
         send({p, 6'b0, a});
         chk(reg_wr_en && !reg_wr_wide, "R1 write strobe", {reg_wr_en, reg_wr_wide}, 2'b10);
         chk(reg_wr_addr == a, "R1 addr", reg_wr_addr, a);
         chk(reg_wr_data == {16'h0, p}, "R1 data", reg_wr_data, {16'h0, p});
      end

      // R2 payload writes
      for (int i = 0; i < 8; i++) begin
         logic [9:0]  a = 10'(i * 97 + 3);
         logic [15:0] p = 16'(i * 1111 + 5);
         logic [31:0] d = 32'h9E37_79B9 * 32'(i + 1);
         send({p, 6'b010000, a});
         chk(!reg_wr_en, "R2 no write on header", reg_wr_en, 0);
         send(d);
         chk(reg_wr_en && reg_wr_wide, "R2 wide strobe", {reg_wr_en, reg_wr_wide}, 2'b11);
         chk(reg_wr_addr == a, "R2 addr", reg_wr_addr, a);
         chk(reg_wr_data == d, "R2 data", reg_wr_data, d);
         chk(reg_wr_aux == p, "R2 aux", reg_wr_aux, p);
      end

      // R3 and R4: each kind, with held requests
      issue_op(10'h002, 16'h1234, 2);
      issue_op(10'h003, 16'h00FF, 0);
      issue_op(10'h005, 16'hA5A5, 1);
      issue_op(10'h006, 16'h0001, 3);
      issue_op(10'h010, 16'(3 * 16 + 5), 2);   // R4 channel 3 mode 5
      issue_op(10'h010, 16'(1 * 16 + 0), 0);   // R4 channel 1 mode 0
      for (int i = 0; i < 4; i++) pulse_done(1'b0);
      for (int i = 0; i < 2; i++) pulse_done(1'b1);

      // R12 ignored opcodes
      foreach (dl[i]) begin end
      for (int i = 0; i < 4; i++) begin
         logic [9:0] o = (i == 0) ? 10'h001 : (i == 1) ? 10'h007 : (i == 2) ? 10'h013 : 10'h0FF;
         send({16'hBEEF, 6'b0, o});
         chk(!reg_wr_en && !op_start && in_ready && !stalled, "R12 ignored",
             {reg_wr_en, op_start, in_ready}, 3'b001);
      end

      wait_sweep(1'b1, 15, dl);
      wait_sweep(1'b0, 3, kl);

      // R10 illegal modes
      for (int m = 2; m < 4; m++) begin
         do_reset();
         send({16'h0, 2'(m), 14'h0105});
         chk(error && !in_ready, "R10 error", {error, in_ready}, 2'b10);
         repeat (3) @(negedge clk);
         chk(error && !in_ready && !reg_wr_en, "R10 sticky", {error, in_ready}, 2'b10);
      end

      // R9 stop
      do_reset();
      send(32'hFFFF_0000);
      chk(done && !in_ready, "R9 done", {done, in_ready}, 2'b10);
      repeat (4) @(negedge clk);
      chk(done && !in_ready && !op_start, "R9 sticky", {done, in_ready}, 2'b10);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule